// File: doc/BRIEF.md
# Four-channel down-counting timer unit

This peripheral holds four independent 32-bit down-counters behind a simple register port. Each counter advances on ticks from its own prescaler, which divides the block clock by 1, 16 or 256. A counter can run free, reload periodically from a reload register, or stop once at zero. It can count over a 16-bit or a 32-bit range.

Each time a counter reaches zero it sets its bit in a shared raw interrupt status. A mask register selects which of these bits reach the single interrupt output. Software clears status bits by writing ones to a clear register.

A register access is a single cycle: a write commits on the rising edge where `psel` and `pwrite` are both high, and `prdata` follows `paddr` combinationally.

Top module: `quad_mtu`

## Requirements
- R1: After reset every register reads zero and `irq` is low. Word offsets are as follows:
  - 0x00: interrupt mask.
  - 0x04: raw status.
  - 0x08: masked status.
  - 0x0C: clear.
  - Timer n has a block at 0x10+0x10*n. Within that block, +0x0 is the load register, +0x4 the current value, +0x8 control and +0xC the reload register.
- R2: Control bits 3:2 pick the prescale ratio, with 00 for 1, 01 for 16 and 10 or 11 for 256. Control bit 7 enables the counter. After a control write that enables a counter, the first decrement happens `div` edges later and the next ones every `div` edges.
- R3: Control bit 1 selects 32-bit counting. When it is clear, the counter works on 16 bits and the current value reads as the low 16 bits of what was loaded.
- R4: In free-running mode (bit 6 and bit 0 clear), a counter at zero wraps on the next tick to the all-ones value of its width.
- R5: A load write sets both the count and the reload register. A write to the reload register leaves the count unchanged. In periodic mode (bit 6 set), a counter at zero reloads on the next tick from the reload register. Both the load and reload offsets read back the reload register.
- R6: In one-shot mode (bit 0 set, which takes priority over bit 6), a counter stays at zero once it gets there, until a new load.
- R7: Raw status bit n sets on the edge where timer n's count becomes zero. Masked status is raw AND mask. `irq` is the OR of the masked bits. Writing 1 to clear-register bit n clears raw bit n; a new event in the same cycle wins.
- R8: Writing 0 to control stops the count on that same edge, and the current value stays readable and unchanged.
- R9: The following read as zero:
  - the clear register;
  - offsets that are not word aligned;
  - timer blocks beyond the last timer;
  - all other unmapped offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the timer clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Access select |
| pwrite | input | 1 | Write when high, read when low |
| paddr | input | 12 | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from `paddr` |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest state to reach from the ports is the zero crossing under each mode and width, with reads taken at exactly known edge counts. The bench stays aligned to falling edges and counts every edge after the enabling control write. It computes the expected value from the load value, the prescale ratio and the mode. Short load values bring the wrap, reload and one-shot stop within a few cycles for every timer. The interrupt path is then driven through mask, masked-status and clear writes while the counter is parked, so no new event can hide a wrong clear.

// File: rtl/mtu_pkg.sv
package mtu_pkg;
    localparam int DW = 32;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'd0,
        PS_DIV16  = 2'd1,
        PS_DIV256 = 2'd2,
        PS_ALT256 = 2'd3
    } pscale_e;

    // control byte, bit 7 down to bit 0
    typedef struct packed {
        logic       en;
        logic       periodic;
        logic [1:0] spare;
        pscale_e    ps;
        logic       wide;
        logic       oneshot;
    } tctl_t;

    localparam logic [1:0] SUB_LOAD = 2'd0;
    localparam logic [1:0] SUB_CUR  = 2'd1;
    localparam logic [1:0] SUB_CTL  = 2'd2;
    localparam logic [1:0] SUB_BG   = 2'd3;

    localparam logic [1:0] SH_MASK = 2'd0;
    localparam logic [1:0] SH_RAW  = 2'd1;
    localparam logic [1:0] SH_MIS  = 2'd2;
    localparam logic [1:0] SH_CLR  = 2'd3;

    function automatic logic [7:0] ps_limit(pscale_e p);
        case (p)
            PS_DIV1:  return 8'd0;
            PS_DIV16: return 8'd15;
            default:  return 8'd255;
        endcase
    endfunction

    function automatic logic [DW-1:0] width_mask(logic wide);
        return wide ? {DW{1'b1}} : {{(DW-16){1'b0}}, 16'hFFFF};
    endfunction
endpackage

// File: rtl/mtu_prescaler.sv
module mtu_prescaler
    import mtu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    input  logic    restart,
    input  pscale_e ps,
    output logic    tick
);
    logic [7:0] pcnt;
    logic [7:0] lim;

    assign lim  = ps_limit(ps);
    assign tick = run && !restart && (pcnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run || restart)
            pcnt <= '0;
        else if (pcnt == lim)
            pcnt <= '0;
        else
            pcnt <= pcnt + 8'd1;
    end
endmodule

// File: rtl/mtu_channel.sv
module mtu_channel
    import mtu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_we,
    input  logic          bg_we,
    input  logic          ctl_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cur_o,
    output logic [DW-1:0] reload_o,
    output tctl_t         ctl_o,
    output logic          ev_o
);
    tctl_t         ctl;
    logic [DW-1:0] count;
    logic [DW-1:0] reload;
    logic [DW-1:0] wmask;
    logic [DW-1:0] cnt_w;
    logic          tick;

    assign wmask    = width_mask(ctl.wide);
    assign cnt_w    = count & wmask;
    assign cur_o    = cnt_w;
    assign reload_o = reload;
    assign ctl_o    = ctl;
    assign ev_o     = tick && !ld_we && (cnt_w == {{(DW-1){1'b0}}, 1'b1});

    mtu_prescaler u_ps (
        .clk     (clk),
        .rst     (rst),
        .run     (ctl.en),
        .restart (ctl_we),
        .ps      (ctl.ps),
        .tick    (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= '0;
            count  <= '0;
            reload <= '0;
        end else begin
            if (ctl_we) ctl <= tctl_t'(wdata[7:0]);
            if (bg_we)  reload <= wdata;
            if (ld_we) begin
                count  <= wdata;
                reload <= wdata;
            end else if (tick) begin
                if (cnt_w == '0) begin
                    if (ctl.oneshot)
                        count <= count;
                    else if (ctl.periodic)
                        count <= reload & wmask;
                    else
                        count <= wmask;
                end else begin
                    count <= (count - 1'b1) & wmask;
                end
            end
        end
    end

    // R8
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.en && !ld_we && !ctl_we) |=> $stable(count));
    // R6
    oneshot_park_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && ctl.oneshot && cnt_w == '0 && !ld_we && !ctl_we) |=> (cur_o == '0));
    // R4
    freerun_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_w == '0 && !ctl.oneshot && !ctl.periodic && !ld_we && !ctl_we)
        |=> (cur_o == width_mask(ctl.wide)));
    // R5
    periodic_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_w == '0 && ctl.periodic && !ctl.oneshot && !ld_we && !ctl_we && !bg_we)
        |=> (cur_o == (reload & width_mask(ctl.wide))));
    // R7
    event_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_o && !ctl_we) |=> (cur_o == '0));
endmodule

// File: rtl/mtu_irq.sv
module mtu_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ev,
    input  logic         mask_we,
    input  logic         clr_we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] mask_o,
    output logic         irq_o
);
    logic [N-1:0] raw;
    logic [N-1:0] mask;
    logic [N-1:0] clr_bits;

    assign clr_bits = clr_we ? wdata : '0;
    assign raw_o    = raw;
    assign mask_o   = mask;
    assign irq_o    = |(raw & mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            raw  <= '0;
            mask <= '0;
        end else begin
            raw <= (raw & ~clr_bits) | ev;
            if (mask_we) mask <= wdata;
        end
    end

    // R7
    raw_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((raw & $past(wdata & ~ev)) == '0));
    // R7
    raw_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|ev) |=> ((raw & $past(ev)) == $past(ev)));
endmodule

// File: rtl/quad_mtu.sv
module quad_mtu
    import mtu_pkg::*;
#(
    parameter int N_TMR = 4,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          psel,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [31:0]   pwdata,
    output logic [31:0]   prdata,
    output logic          irq
);
    localparam int BW = AW - 4;

    logic          wr;
    logic          aligned;
    logic [BW-1:0] blk;
    logic [1:0]    sub;
    logic [N_TMR-1:0] ev;
    logic [N_TMR-1:0] raw;
    logic [N_TMR-1:0] mask;
    logic [DW-1:0] cur    [N_TMR];
    logic [DW-1:0] reload [N_TMR];
    tctl_t         ctl    [N_TMR];

    assign wr      = psel && pwrite;
    assign aligned = (paddr[1:0] == 2'b00);
    assign blk     = paddr[AW-1:4];
    assign sub     = paddr[3:2];

    for (genvar n = 0; n < N_TMR; n++) begin : g_tmr
        logic hit;
        assign hit = wr && aligned && (blk == BW'(n + 1));
        mtu_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .ld_we    (hit && sub == SUB_LOAD),
            .bg_we    (hit && sub == SUB_BG),
            .ctl_we   (hit && sub == SUB_CTL),
            .wdata    (pwdata),
            .cur_o    (cur[n]),
            .reload_o (reload[n]),
            .ctl_o    (ctl[n]),
            .ev_o     (ev[n])
        );
    end

    mtu_irq #(.N(N_TMR)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .mask_we (wr && aligned && blk == '0 && sub == SH_MASK),
        .clr_we  (wr && aligned && blk == '0 && sub == SH_CLR),
        .wdata   (pwdata[N_TMR-1:0]),
        .raw_o   (raw),
        .mask_o  (mask),
        .irq_o   (irq)
    );

    always_comb begin
        prdata = '0;
        if (aligned) begin
            if (blk == '0) begin
                case (sub)
                    SH_MASK: prdata = {{(32-N_TMR){1'b0}}, mask};
                    SH_RAW:  prdata = {{(32-N_TMR){1'b0}}, raw};
                    SH_MIS:  prdata = {{(32-N_TMR){1'b0}}, raw & mask};
                    default: prdata = '0;
                endcase
            end
            for (int n = 0; n < N_TMR; n++) begin
                if (blk == BW'(n + 1)) begin
                    case (sub)
                        SUB_CUR: prdata = cur[n];
                        SUB_CTL: prdata = {24'd0, ctl[n]};
                        default: prdata = reload[n];
                    endcase
                end
            end
        end
    end

    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((raw & mask) != '0));
endmodule

// File: tb/quad_mtu_test.sv
module quad_mtu_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    quad_mtu uut (
        .clk(clk), .rst(rst), .psel(psel), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
    );

    task automatic wr(input int a, input logic [31:0] d);
        paddr = 12'(a); pwdata = d; psel = 1'b1; pwrite = 1'b1;
        @(negedge clk);
        psel = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        paddr = 12'(a); psel = 1'b1; pwrite = 1'b0;
        #1 d = prdata;
        psel = 1'b0;
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_reg(input string req, input int a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 20; a++) chk_reg("R1", a * 4, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);

        for (int n = 0; n < 4; n++) begin
            int tb;
            int bit_n;
            tb = 16 + 16 * n;
            bit_n = 1 << n;
            // R2 prescale sweep
            for (int p = 0; p < 3; p++) begin
                int dv;
                int k;
                dv = (p == 0) ? 1 : (p == 1) ? 16 : 256;
                k = 2 * dv + 3;
                wr(tb, 32'd40);
                wr(tb + 8, 32'h82 | (p << 2));
                repeat (k) @(negedge clk);
                chk_reg("R2", tb + 4, 32'(40 - k / dv));
                wr(tb + 8, 32'd0);
            end
            // R3 16-bit view of load
            wr(tb, 32'hABCD0007);
            chk_reg("R3", tb + 4, 32'h0007);
            // R4 16-bit wrap, R7 raw set
            wr(12, 32'hF);
            wr(tb, 32'd2);
            wr(tb + 8, 32'h80);
            repeat (3) @(negedge clk);
            chk_reg("R4 16b", tb + 4, 32'h0000FFFF);
            wr(tb + 8, 32'd0);
            chk_reg("R7 raw", 4, 32'(bit_n));
            check("R7 irq masked off", {31'd0, irq}, 32'd0);
            wr(0, 32'(bit_n));
            check("R7 irq", {31'd0, irq}, 32'd1);
            chk_reg("R7 mis", 8, 32'(bit_n));
            wr(12, 32'(bit_n));
            chk_reg("R7 clear", 4, 32'd0);
            check("R7 irq clear", {31'd0, irq}, 32'd0);
            wr(0, 32'd0);
            // R4 32-bit wrap
            wr(tb, 32'd1);
            wr(tb + 8, 32'h82);
            repeat (2) @(negedge clk);
            chk_reg("R4 32b", tb + 4, 32'hFFFFFFFF);
            wr(tb + 8, 32'd0);
            // R5 reload register and periodic mode
            wr(tb, 32'd3);
            wr(tb + 12, 32'd10);
            chk_reg("R5 count kept", tb + 4, 32'd3);
            chk_reg("R5 reload read", tb, 32'd10);
            wr(tb + 8, 32'hC2);
            repeat (5) @(negedge clk);
            chk_reg("R5 periodic", tb + 4, 32'd9);
            wr(tb + 8, 32'd0);
            // R6 one-shot parks at zero
            wr(12, 32'hF);
            wr(tb, 32'd3);
            wr(tb + 8, 32'hC3);
            repeat (10) @(negedge clk);
            chk_reg("R6 park", tb + 4, 32'd0);
            chk_reg("R6 raw", 4, 32'(bit_n));
            wr(tb + 8, 32'd0);
            wr(12, 32'hF);
            // R8 immediate stop
            wr(tb, 32'd100);
            wr(tb + 8, 32'h82);
            repeat (4) @(negedge clk);
            wr(tb + 8, 32'd0);
            chk_reg("R8 stop", tb + 4, 32'd96);
            repeat (5) @(negedge clk);
            chk_reg("R8 hold", tb + 4, 32'd96);
            chk_reg("R8 ctl", tb + 8, 32'd0);
        end
        // R9 unmapped reads
        chk_reg("R9 clr", 12, 32'd0);
        chk_reg("R9 blk5", 16'h54, 32'd0);
        chk_reg("R9 far", 16'h200, 32'd0);
        chk_reg("R9 unaligned", 16'h15, 32'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule